// File: doc/BRIEF.md
# Power Button and Host Request Arbiter

This block sits between the debounced front-panel inputs, the application processor's request pins and the platform power controller. It turns levels and edges on those pins into short request pulses and two sticky flags that the power controller reads and acknowledges. A press of the power button while the platform is off asks for a boot after a short continuous hold. A much longer hold asks for a forced shutdown in any state. Opening the lid while the platform is off asks for a boot at once.

The processor has two request pins. A rising edge on the warm-reset pin drives the active-low system reset line low for a fixed time. An assertion of the active-low shutdown pin marks a shutdown as pending, unless a warm-reset request came in since the previous edge on the shutdown pin. In that case the shutdown edge is taken as part of a reboot. The flags stay set until the power controller clears them with its acknowledge inputs.

All durations are given in milliseconds and scaled by a cycles-per-millisecond parameter. The defaults are a 10 ms boot hold, an 8000 ms forced-off hold and a 30 ms reset pulse. Debouncing of the raw pins and the power state machine itself lie outside this block.

Top module: `pwr_req_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, boot_req and force_off are 0, shdn_pending and boot_flag are 0, and sys_rst_n is 1.
- R2: A press that the clock samples with plat_off high, and that stays held for N = BOOT_MS*TICK_CYCLES further edges, gives boot_req high for one cycle, N cycles after the press edge. A hold one edge shorter gives no pulse. A press with plat_off low gives no boot request.
- R3: Any press held for M = LONG_MS*TICK_CYCLES further edges gives force_off high for one cycle, M cycles after the press edge, and sets shdn_pending. The boot and forced-off timers run side by side from one press.
- R4: Releasing the button cancels both timers. A new press restarts both timers from zero.
- R5: Every boot request, from the button or from the lid, clears shdn_pending and sets boot_flag. When a set and a clear of the same flag land in one cycle, the set wins.
- R6: A rising edge of lid_open while plat_off is high gives boot_req in the next cycle. A lid edge while plat_off is low is ignored.
- R7: A rising edge of warm_req drives sys_rst_n low from the next cycle for exactly R = RST_MS*TICK_CYCLES cycles, then releases it.
- R8: A warm_req rising edge while the reset pulse is running is ignored. It neither lengthens the pulse nor counts as a reboot request.
- R9: A falling edge of shdn_req_n sets shdn_pending only if no accepted warm-reset request has come in since the last edge of either polarity on shdn_req_n. Every edge on shdn_req_n forgets the earlier warm request.
- R10: boot_ack clears boot_flag and shdn_ack clears shdn_pending, each from the next cycle, unless a set of that flag happens in the same cycle.
- R11: Input levels already present when reset is released are not edges. A button, lid or warm-reset pin held active through reset triggers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_off | input | 1 | High while the platform is in an off state |
| btn_pressed | input | 1 | Debounced power button, high while pressed |
| lid_open | input | 1 | Debounced lid switch, high when open |
| warm_req | input | 1 | Processor warm-reset request, acted on at its rising edge |
| shdn_req_n | input | 1 | Processor shutdown request, active low |
| boot_ack | input | 1 | Power controller clears boot_flag |
| shdn_ack | input | 1 | Power controller clears shdn_pending |
| boot_req | output | 1 | One-cycle request to leave the off state |
| force_off | output | 1 | One-cycle forced-shutdown request after a long hold |
| shdn_pending | output | 1 | Sticky flag: a shutdown is wanted |
| boot_flag | output | 1 | Sticky flag: the boot was started from off |
| sys_rst_n | output | 1 | Active-low system reset line |

## Verification
The assertions assume that the inputs come from synchronous, debounced sources, so each input changes at most once per clock and never between edges in a way that splits a pulse. They also assume that reset is applied from time zero. The stimulus changes every input on the falling clock edge and keeps each level for at least one full cycle. It holds the button for exact edge counts around each threshold and separates successive warm-reset requests by a low phase. This keeps edge detection and timer lengths unambiguous.

// File: rtl/pwr_req_arbiter.sv
module pwr_req_arbiter #(
  parameter int TICK_CYCLES = 32000,
  parameter int BOOT_MS     = 10,
  parameter int LONG_MS     = 8000,
  parameter int RST_MS      = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic plat_off,
  input  logic btn_pressed,
  input  logic lid_open,
  input  logic warm_req,
  input  logic shdn_req_n,
  input  logic boot_ack,
  input  logic shdn_ack,
  output logic boot_req,
  output logic force_off,
  output logic shdn_pending,
  output logic boot_flag,
  output logic sys_rst_n
);

  localparam int BOOT_CYC = BOOT_MS * TICK_CYCLES;
  localparam int LONG_CYC = LONG_MS * TICK_CYCLES;
  localparam int RST_CYC  = RST_MS * TICK_CYCLES;
  localparam int BW = $clog2(BOOT_CYC + 1);
  localparam int LW = $clog2(LONG_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [BW-1:0] BOOT_LAST = BW'(BOOT_CYC - 1);
  localparam logic [LW-1:0] LONG_LAST = LW'(LONG_CYC - 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_CYC - 1);

  logic btn_q, lid_q, warm_q, shdn_q;
  logic boot_arm, long_arm, rst_act, reboot_seen;
  logic [BW-1:0] boot_cnt;
  logic [LW-1:0] long_cnt;
  logic [RW-1:0] rst_cnt;

  wire press       = btn_pressed & ~btn_q;
  wire lid_rise    = lid_open & ~lid_q;
  wire warm_take   = warm_req & ~warm_q & ~rst_act;
  wire shdn_fall   = ~shdn_req_n & shdn_q;
  wire shdn_edge   = shdn_req_n ^ shdn_q;
  wire held        = btn_pressed & ~press;
  wire boot_hit    = held & boot_arm & (boot_cnt == BOOT_LAST);
  wire long_hit    = held & long_arm & (long_cnt == LONG_LAST);
  wire boot_now    = boot_hit | (lid_rise & plat_off);
  wire shdn_take   = shdn_fall & ~reboot_seen & ~warm_take;

  assign sys_rst_n = ~rst_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= 1'b1;
      lid_q  <= 1'b1;
      warm_q <= 1'b1;
      shdn_q <= 1'b0;
    end else begin
      btn_q  <= btn_pressed;
      lid_q  <= lid_open;
      warm_q <= warm_req;
      shdn_q <= shdn_req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_arm <= 1'b0;
      boot_cnt <= '0;
    end else if (press) begin
      boot_arm <= plat_off;
      boot_cnt <= '0;
    end else if (!btn_pressed || boot_hit) begin
      boot_arm <= 1'b0;
    end else if (boot_arm) begin
      boot_cnt <= boot_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_arm <= 1'b0;
      long_cnt <= '0;
    end else if (press) begin
      long_arm <= 1'b1;
      long_cnt <= '0;
    end else if (!btn_pressed || long_hit) begin
      long_arm <= 1'b0;
    end else if (long_arm) begin
      long_cnt <= long_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_act <= 1'b0;
      rst_cnt <= '0;
    end else if (warm_take) begin
      rst_act <= 1'b1;
      rst_cnt <= '0;
    end else if (rst_act) begin
      if (rst_cnt == RST_LAST) rst_act <= 1'b0;
      else                     rst_cnt <= rst_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reboot_seen <= 1'b0;
    else if (shdn_edge) reboot_seen <= 1'b0;
    else if (warm_take) reboot_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_req     <= 1'b0;
      force_off    <= 1'b0;
      shdn_pending <= 1'b0;
      boot_flag    <= 1'b0;
    end else begin
      boot_req  <= boot_now;
      force_off <= long_hit;
      if (long_hit || shdn_take)     shdn_pending <= 1'b1;
      else if (boot_now || shdn_ack) shdn_pending <= 1'b0;
      if (boot_now)      boot_flag <= 1'b1;
      else if (boot_ack) boot_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_req_arbiter_chk.sv
module pwr_req_arbiter_chk #(
  parameter int RST_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic btn_pressed,
  input logic boot_req,
  input logic force_off,
  input logic shdn_pending,
  input logic boot_flag,
  input logic sys_rst_n
);

  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (!sys_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  // R7 and R8: every low phase of the reset line lasts exactly RST_CYC cycles
  a_r7_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> low_cnt == RST_CYC);

  a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> low_cnt < RST_CYC);

  a_r3_force_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> $past(btn_pressed));

  a_r3_force_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> shdn_pending);

  a_r5_boot_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |-> boot_flag);

endmodule

bind pwr_req_arbiter pwr_req_arbiter_chk #(.RST_CYC(RST_MS * TICK_CYCLES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .btn_pressed(btn_pressed),
  .boot_req(boot_req),
  .force_off(force_off),
  .shdn_pending(shdn_pending),
  .boot_flag(boot_flag),
  .sys_rst_n(sys_rst_n)
);

// File: tb/pwr_req_arbiter_bench.sv
module pwr_req_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 2;
  localparam int BOOT_N = 10 * TICK;
  localparam int LONG_N = 40 * TICK;
  localparam int RST_N  = 5 * TICK;

  localparam int NV = 7;
  localparam int V_OFF[NV]   = '{1, 1, 0, 1, 0, 0, 1};
  localparam int V_HOLD[NV]  = '{BOOT_N + 1, BOOT_N, BOOT_N + 1, LONG_N + 1, LONG_N + 1, LONG_N, 3};
  localparam int V_BOOT[NV]  = '{1, 0, 0, 1, 0, 0, 0};
  localparam int V_FORCE[NV] = '{0, 0, 0, 1, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic plat_off = 1'b1, btn_pressed = 1'b1, lid_open = 1'b1, warm_req = 1'b1;
  logic shdn_req_n = 1'b1, boot_ack = 1'b0, shdn_ack = 1'b0;
  logic boot_req, force_off, shdn_pending, boot_flag, sys_rst_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_req_arbiter #(.TICK_CYCLES(TICK), .BOOT_MS(10), .LONG_MS(40), .RST_MS(5)) u_pwr_req_arbiter (
    .clk(clk), .rst_n(rst_n), .plat_off(plat_off), .btn_pressed(btn_pressed),
    .lid_open(lid_open), .warm_req(warm_req), .shdn_req_n(shdn_req_n),
    .boot_ack(boot_ack), .shdn_ack(shdn_ack), .boot_req(boot_req),
    .force_off(force_off), .shdn_pending(shdn_pending), .boot_flag(boot_flag),
    .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    boot_ack = 1'b1; shdn_ack = 1'b1;
    @(negedge clk);
    boot_ack = 1'b0; shdn_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int nb, nf, at, lows;
    repeat (3) @(negedge clk);
    chk("R1 boot_req", boot_req, 0);
    chk("R1 force_off", force_off, 0);
    chk("R1 shdn_pending", shdn_pending, 0);
    chk("R1 boot_flag", boot_flag, 0);
    chk("R1 sys_rst_n", sys_rst_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle boot_req", boot_req, 0);
    nb = 0;
    for (int i = 0; i < LONG_N + 10; i++) begin
      @(negedge clk);
      nb += int'(boot_req) + int'(force_off) + int'(!sys_rst_n);
    end
    chk("R11 no action from levels held at reset", nb, 0);
    btn_pressed = 1'b0; lid_open = 1'b0; warm_req = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      plat_off = V_OFF[v][0];
      btn_pressed = 1'b1;
      nb = 0; nf = 0;
      for (int k = 0; k < V_HOLD[v]; k++) begin
        @(negedge clk);
        nb += int'(boot_req); nf += int'(force_off);
      end
      btn_pressed = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        nb += int'(boot_req); nf += int'(force_off);
      end
      chk("R2 boot pulses", nb, V_BOOT[v]);
      chk("R3 force pulses", nf, V_FORCE[v]);
      chk("R3 shdn_pending after hold", shdn_pending, V_FORCE[v]);
      chk("R5 boot_flag after hold", boot_flag, V_BOOT[v]);
      clear_flags();
    end

    plat_off = 1'b1;
    btn_pressed = 1'b1;
    repeat (15) @(negedge clk);
    btn_pressed = 1'b0;
    repeat (2) @(negedge clk);
    btn_pressed = 1'b1;
    nb = 0; at = -1;
    for (int i = 1; i <= BOOT_N + 10; i++) begin
      @(negedge clk);
      if (boot_req) begin nb++; at = i; end
    end
    btn_pressed = 1'b0;
    chk("R4 restart gives one boot", nb, 1);
    chk("R4 restart boot timing", at, BOOT_N + 1);
    @(negedge clk);
    clear_flags();

    shdn_req_n = 1'b0;
    @(negedge clk);
    chk("R9 plain shutdown sets pending", shdn_pending, 1);
    shdn_req_n = 1'b1;
    @(negedge clk);
    lid_open = 1'b1;
    @(negedge clk);
    chk("R6 lid boot_req", boot_req, 1);
    chk("R5 lid clears pending", shdn_pending, 0);
    chk("R5 lid sets flag", boot_flag, 1);
    @(negedge clk);
    chk("R6 boot_req single cycle", boot_req, 0);
    lid_open = 1'b0;
    clear_flags();
    plat_off = 1'b0;
    lid_open = 1'b1;
    nb = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      nb += int'(boot_req);
    end
    chk("R6 lid while on ignored", nb, 0);
    chk("R6 lid while on leaves flag", boot_flag, 0);
    lid_open = 1'b0;
    @(negedge clk);

    warm_req = 1'b1;
    @(negedge clk);
    chk("R7 reset low next cycle", sys_rst_n, 0);
    lows = 1;
    for (int i = 0; i < 2 * RST_N; i++) begin
      @(negedge clk);
      lows += int'(!sys_rst_n);
    end
    chk("R7 reset width", lows, RST_N);
    warm_req = 1'b0;
    @(negedge clk);

    warm_req = 1'b1;
    lows = 0;
    for (int i = 0; i < 3 * RST_N; i++) begin
      @(negedge clk);
      lows += int'(!sys_rst_n);
      if (i == 3) warm_req = 1'b0;
      if (i == 4) warm_req = 1'b1;
      if (i == RST_N + 2) warm_req = 1'b0;
    end
    chk("R8 repeat request ignored", lows, RST_N);

    shdn_req_n = 1'b0;
    @(negedge clk);
    chk("R9 shutdown after warm is a reboot", shdn_pending, 0);
    shdn_req_n = 1'b1;
    @(negedge clk);
    shdn_req_n = 1'b0;
    @(negedge clk);
    chk("R9 later shutdown honoured", shdn_pending, 1);
    shdn_ack = 1'b1;
    @(negedge clk);
    shdn_ack = 1'b0;
    chk("R10 shdn_ack clears", shdn_pending, 0);
    shdn_req_n = 1'b1;
    @(negedge clk);

    warm_req = 1'b1;
    @(negedge clk);
    warm_req = 1'b0;
    repeat (RST_N + 2) @(negedge clk);
    shdn_req_n = 1'b0;
    @(negedge clk);
    chk("R9 warm then shutdown no pending", shdn_pending, 0);
    shdn_req_n = 1'b1;
    @(negedge clk);

    plat_off = 1'b1;
    boot_ack = 1'b1;
    btn_pressed = 1'b1;
    repeat (BOOT_N + 1) @(negedge clk);
    chk("R10 boot pulse with ack held", boot_req, 1);
    chk("R10 set wins over ack", boot_flag, 1);
    @(negedge clk);
    chk("R10 boot_ack clears", boot_flag, 0);
    btn_pressed = 1'b0;
    boot_ack = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule